// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM from power-up to a ready state. It owns the SDRAM command and address pins from reset until it raises `init_done`. While it is not done, it first drives only NOP for a long settling window. It then closes every bank with one precharge and runs two auto-refresh cycles. Last, it writes the mode register with a word packed from elaboration parameters. After `init_done` rises, the block drives NOP with a zero address so the access and refresh logic can take over the pins.

Every wait is a clock-cycle count. Each count is derived from a nanosecond parameter and the clock period, rounded up. The mode word carries the burst length, the burst ordering, the CAS latency and the write-burst policy. The reserved and operating-mode bits are held at zero.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst_n` is low, the pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), the address and bank are zero, and `init_done` is low.
- R2: After reset is released, the first WAIT_CYC sampled cycles are all NOP. WAIT_CYC is ceil(POWERUP_WAIT_NS*1000/CLK_PERIOD_PS), with a minimum of 1.
- R3: The precharge-all command (0010 with address bit 10 high, all other address bits and the bank zero) appears exactly WAIT_CYC rising edges after reset release. It is the first command that is not NOP.
- R4: Exactly two auto-refresh commands (0001, address and bank zero) follow. The first comes TRP_CYC cycles after the precharge. The second comes TRFC_CYC cycles after the first.
- R5: The load-mode command (0000, bank zero) comes TRFC_CYC cycles after the second refresh. It is issued only once.
- R6: The mode word on the address pins during load-mode is laid out as follows:
  - bits [2:0] hold the burst code: 1 word gives 0, 2 gives 1, 4 gives 2, 8 gives 3, and BURST_WORDS=0 (full page) gives 7.
  - bit 3 is 1 for interleaved ordering.
  - bits [6:4] hold the CAS latency (1 to 4) in binary.
  - bit 9 is 1 for single-location writes.
  - bits [8:7], [12:10] and any address bits above 12 are zero.
- R7: If full page is combined with interleaved ordering, bit 3 of the mode word is forced to 0 (sequential).
- R8: Every cycle between two commands is NOP. The gap counts are TRP_CYC and TRFC_CYC, each rounded up from its nanosecond value, and TMRD_CYC = T_MRD_CYC. Each of these three is at least 2, so two commands are never adjacent.
- R9: `init_done` rises exactly TMRD_CYC cycles after the load-mode cycle. It then stays high with NOP and a zero address until the next reset.
- R10: A reset applied partway through the sequence restarts it from the full settling window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | ADDR_W | SDRAM address; bit 10 selects all banks on precharge, mode word on load-mode |
| sd_ba | output | BANK_W | SDRAM bank address, zero throughout |
| init_done | output | 1 | High once the mode-register delay has elapsed; sticky until reset |

## Verification
A wrong state or a misloaded gap counter shows up at the pins as a command that is not NOP appearing at the wrong cycle index. It can also show up as a missing or extra command. The per-event scoreboard catches this on the very cycle the first misplaced command appears. A mistake in the mode word shows up only on the single load-mode cycle, as a wrong address value. Two instances, one with default parameters and one with short timings and a full-page interleaved request, expose both the rounding and the clamp paths. A late or dropped `init_done` is caught the cycle before and the cycle at its expected rise.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_WAIT, ST_PRE, ST_TRP, ST_REF1, ST_TRFC1,
    ST_REF2, ST_TRFC2, ST_LMR, ST_TMRD, ST_DONE
  } seq_state_e;

  // Rounded-up cycle count for a time in ns, never below floor_cyc.
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ps,
                                               int unsigned floor_cyc);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < floor_cyc) ? floor_cyc : c;
  endfunction

  // Burst length field; any unlisted size means full page.
  function automatic logic [2:0] burst_code(int unsigned words);
    case (words)
      1:       return 3'd0;
      2:       return 3'd1;
      4:       return 3'd2;
      8:       return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [12:0] pack_mode(int unsigned words, int unsigned interleave,
                                            int unsigned cas, int unsigned wr_single);
    logic [12:0] w;
    logic [2:0]  bl;
    bl      = burst_code(words);
    w       = '0;
    w[2:0]  = bl;
    w[3]    = (interleave != 0) && (bl != 3'd7);
    w[6:4]  = cas[2:0];
    w[9]    = (wr_single != 0);
    return w;
  endfunction

  function automatic sd_cmd_e cmd_of_state(seq_state_e s);
    case (s)
      ST_PRE:           return CMD_PRE;
      ST_REF1, ST_REF2: return CMD_REF;
      ST_LMR:           return CMD_LMR;
      default:          return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdi_gap_timer.sv
module sdi_gap_timer #(
  parameter int CNT_W     = 16,
  parameter int RESET_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= CNT_W'(RESET_VAL);
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdi_mode_builder.sv
module sdi_mode_builder #(
  parameter int BURST_WORDS      = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_LATENCY      = 2,
  parameter int WRITE_SINGLE     = 0
) (
  output logic [12:0] mode_word
);
  assign mode_word = sdi_pkg::pack_mode(BURST_WORDS, BURST_INTERLEAVE,
                                        CAS_LATENCY, WRITE_SINGLE);
endmodule

// File: rtl/sdi_pin_drive.sv
module sdi_pin_drive #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  sdi_pkg::seq_state_e state,
  input  logic [12:0]         mode_word,
  output logic                cs_n,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ADDR_W-1:0]   addr,
  output logic [BANK_W-1:0]   ba
);
  import sdi_pkg::*;
  sd_cmd_e cmd;

  assign cmd = cmd_of_state(state);
  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba = '0;

  always_comb begin
    addr = '0;
    if (state == ST_PRE)      addr[10] = 1'b1;
    else if (state == ST_LMR) addr = ADDR_W'(mode_word);
  end
endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int CLK_PERIOD_PS    = 8000,
  parameter int POWERUP_WAIT_NS  = 100000,
  parameter int T_RP_NS          = 20,
  parameter int T_RFC_NS         = 70,
  parameter int T_MRD_CYC        = 2,
  parameter int ADDR_W           = 13,
  parameter int BANK_W           = 2,
  parameter int BURST_WORDS      = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_LATENCY      = 2,
  parameter int WRITE_SINGLE     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic              init_done
);
  import sdi_pkg::*;

  localparam int WAIT_CYC = ns_to_cycles(POWERUP_WAIT_NS, CLK_PERIOD_PS, 1);
  localparam int TRP_CYC  = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS, 2);
  localparam int TRFC_CYC = ns_to_cycles(T_RFC_NS, CLK_PERIOD_PS, 2);
  localparam int TMRD_CYC = (T_MRD_CYC < 2) ? 2 : T_MRD_CYC;
  localparam int CNT_W    = $clog2(WAIT_CYC + TRP_CYC + TRFC_CYC + TMRD_CYC + 1);
  localparam logic [CNT_W-1:0] TRP_LD  = CNT_W'(TRP_CYC - 2);
  localparam logic [CNT_W-1:0] TRFC_LD = CNT_W'(TRFC_CYC - 2);
  localparam logic [CNT_W-1:0] TMRD_LD = CNT_W'(TMRD_CYC - 2);

  seq_state_e       state_q, state_d;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic [12:0]      mode_word;

  sdi_gap_timer #(.CNT_W(CNT_W), .RESET_VAL(WAIT_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  sdi_mode_builder #(
    .BURST_WORDS(BURST_WORDS), .BURST_INTERLEAVE(BURST_INTERLEAVE),
    .CAS_LATENCY(CAS_LATENCY), .WRITE_SINGLE(WRITE_SINGLE)
  ) u_mode (.mode_word(mode_word));

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_WAIT:  if (tmr_expired) state_d = ST_PRE;
      ST_PRE:   begin state_d = ST_TRP;   tmr_load = 1'b1; tmr_val = TRP_LD;  end
      ST_TRP:   if (tmr_expired) state_d = ST_REF1;
      ST_REF1:  begin state_d = ST_TRFC1; tmr_load = 1'b1; tmr_val = TRFC_LD; end
      ST_TRFC1: if (tmr_expired) state_d = ST_REF2;
      ST_REF2:  begin state_d = ST_TRFC2; tmr_load = 1'b1; tmr_val = TRFC_LD; end
      ST_TRFC2: if (tmr_expired) state_d = ST_LMR;
      ST_LMR:   begin state_d = ST_TMRD;  tmr_load = 1'b1; tmr_val = TMRD_LD; end
      ST_TMRD:  if (tmr_expired) state_d = ST_DONE;
      ST_DONE:  state_d = ST_DONE;
      default:  state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT;
    else        state_q <= state_d;
  end

  sdi_pin_drive #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_pins (
    .state(state_q), .mode_word(mode_word),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .addr(sd_addr), .ba(sd_ba)
  );

  assign init_done = (state_q == ST_DONE);

  // Pin-level observation points for the assertions.
  logic [3:0]       pin_cmd;
  logic             pin_issue;
  logic [CNT_W-1:0] nop_seen;
  logic [1:0]       ref_seen;

  assign pin_cmd   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign pin_issue = (pin_cmd != CMD_NOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nop_seen <= '0;
      ref_seen <= '0;
    end else begin
      if (!pin_issue && nop_seen != CNT_W'(WAIT_CYC)) nop_seen <= nop_seen + 1'b1;
      if (pin_cmd == CMD_REF && ref_seen != 2'd3)     ref_seen <= ref_seen + 1'b1;
    end
  end

  assert_wait_nops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_PRE) |-> (nop_seen == CNT_W'(WAIT_CYC)));
  assert_pre_allbanks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_PRE) |-> (sd_addr[10] && sd_ba == '0));
  assert_ref_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_REF) |-> (ref_seen < 2'd2));
  assert_lmr_after_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_LMR) |-> (ref_seen == 2'd2));
  assert_mode_zero_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_LMR) |-> (sd_addr[8:7] == 2'b00 && sd_addr[12:10] == 3'b000 && sd_ba == '0));
  assert_gap_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_issue |=> !pin_issue);
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (!pin_issue && sd_addr == '0));
endmodule

// File: tb/sim_sdram_powerup_seq.sv
`timescale 1ns/1ps
module sim_sdram_powerup_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cs0, ras0, cas0, we0, dn0, cs1, ras1, cas1, we1, dn1;
  logic [12:0] a0, a1;
  logic [1:0]  b0, b1;

  sdram_powerup_seq u0 (.clk(clk), .rst_n(rst_n), .sd_cs_n(cs0), .sd_ras_n(ras0),
    .sd_cas_n(cas0), .sd_we_n(we0), .sd_addr(a0), .sd_ba(b0), .init_done(dn0));

  sdram_powerup_seq #(.POWERUP_WAIT_NS(200), .T_RP_NS(5), .T_RFC_NS(10), .T_MRD_CYC(1),
    .BURST_WORDS(0), .BURST_INTERLEAVE(1), .CAS_LATENCY(3), .WRITE_SINGLE(1)) u1 (
    .clk(clk), .rst_n(rst_n), .sd_cs_n(cs1), .sd_ras_n(ras1), .sd_cas_n(cas1),
    .sd_we_n(we1), .sd_addr(a1), .sd_ba(b1), .init_done(dn1));

  typedef struct { int cyc; logic [3:0] cmd; logic [12:0] addr; logic [1:0] ba; string req; } ev_t;
  ev_t q0[$];
  ev_t q1[$];
  int n, checks, fails;
  int pre_at[2], done_at[2];
  bit over;

  always @(posedge clk) if (!rst_n) n <= 0; else n <= n + 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, n);
    end
  endtask

  function automatic int cyc_of(int ns, int ps, int lo);
    int c = ns * 1000 / ps;
    if (c * ps < ns * 1000) c = c + 1;
    if (c < lo) c = lo;
    return c;
  endfunction

  function automatic logic [12:0] exp_mode(int words, int il, int cl, int ws);
    logic [12:0] m = 13'd0;
    if (words == 1) m[2:0] = 3'b000;
    else if (words == 2) m[2:0] = 3'b001;
    else if (words == 4) m[2:0] = 3'b010;
    else if (words == 8) m[2:0] = 3'b011;
    else m[2:0] = 3'b111;
    if (il != 0 && words != 0) m[3] = 1'b1;
    m[6:4] = cl[2:0];
    m[9] = (ws != 0);
    return m;
  endfunction

  // Driver: pushes the expected command events for one instance.
  task automatic plan(int id, int w, int trp, int trfc, int tmrd, logic [12:0] mw, string mreq);
    ev_t e;
    int t = w;
    pre_at[id] = t;
    e = '{t, 4'b0010, 13'h0400, 2'b00, "R3"};   if (id == 0) q0.push_back(e); else q1.push_back(e);
    t = t + trp;
    e = '{t, 4'b0001, 13'h0000, 2'b00, "R4"};   if (id == 0) q0.push_back(e); else q1.push_back(e);
    t = t + trfc;
    e = '{t, 4'b0001, 13'h0000, 2'b00, "R4"};   if (id == 0) q0.push_back(e); else q1.push_back(e);
    t = t + trfc;
    e = '{t, 4'b0000, mw, 2'b00, mreq};         if (id == 0) q0.push_back(e); else q1.push_back(e);
    done_at[id] = t + tmrd;
  endtask

  task automatic plan_all();
    q0.delete(); q1.delete();
    plan(0, cyc_of(100000, 8000, 1), cyc_of(20, 8000, 2), cyc_of(70, 8000, 2), 2,
         exp_mode(4, 0, 2, 0), "R5 R6");
    plan(1, cyc_of(200, 8000, 1), cyc_of(5, 8000, 2), cyc_of(10, 8000, 2), 2,
         exp_mode(0, 1, 3, 1), "R6 R7");
  endtask

  // Monitor: pops and compares as commands appear on the pins.
  task automatic mon(int id, logic [3:0] c, logic [12:0] a, logic [1:0] b, logic d);
    ev_t e;
    bit empty = (id == 0) ? (q0.size() == 0) : (q1.size() == 0);
    if (c != 4'b0111) begin
      if (empty) check(1'b0, "R4", "extra command", c, 7);
      else begin
        if (id == 0) e = q0.pop_front(); else e = q1.pop_front();
        check(n == e.cyc, e.req, "command cycle", n, e.cyc);
        check(c == e.cmd, e.req, "command code", c, e.cmd);
        check(a == e.addr, e.req, "address", a, e.addr);
        check(b == e.ba, e.req, "bank", b, e.ba);
      end
    end
    if (n == pre_at[id] - 1) check(c == 4'b0111, "R2", "last wait cycle", c, 7);
    if (n == pre_at[id] + 1) check(c == 4'b0111, "R8", "gap after precharge", c, 7);
    if (n == done_at[id] - 1) check(d == 1'b0, "R9", "done early", d, 0);
    if (n == done_at[id])     check(d == 1'b1, "R9", "done rise", d, 1);
    if (n == done_at[id] + 4) check(d && c == 4'b0111 && a == 13'd0, "R9", "done hold", {d, c}, 5'h17);
  endtask

  always @(negedge clk) if (rst_n && !over) begin
    mon(0, {cs0, ras0, cas0, we0}, a0, b0, dn0);
    mon(1, {cs1, ras1, cas1, we1}, a1, b1, dn1);
  end

  task automatic reset_state(string req);
    check({cs0, ras0, cas0, we0} == 4'b0111 && {cs1, ras1, cas1, we1} == 4'b0111, req, "reset cmd",
          {cs0, ras0, cas0, we0}, 7);
    check(a0 == 0 && a1 == 0 && b0 == 0 && b1 == 0, req, "reset addr", a0 | a1, 0);
    check(!dn0 && !dn1, req, "reset done", {dn0, dn1}, 0);
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_state("R1");
    plan_all();
    @(posedge clk); #1 rst_n = 1'b1;
    while (n < done_at[0] + 10) @(negedge clk);
    check(q0.size() == 0 && q1.size() == 0, "R4", "pending events", q0.size() + q1.size(), 0);
    // R10: abort the next run just after its first refresh.
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    plan_all();
    @(posedge clk); #1 rst_n = 1'b1;
    while (n < pre_at[0] + 5) @(negedge clk);
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    reset_state("R10");
    plan_all();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    while (n < done_at[0] + 10) @(negedge clk);
    check(q0.size() == 0 && q1.size() == 0, "R10", "pending events", q0.size() + q1.size(), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n, done_at[0]);
    finish_run();
  end
endmodule